// File: doc/BRIEF.md
# Flash Read Prefetch Accelerator

This block sits between a 32-bit instruction-fetch port and a wide embedded flash array. It serves code reads from two line buffers. Each buffer holds one flash line, which is 128 bits wide by default or 64 bits in the narrow mode. Byte, halfword and word reads are taken from the buffered line. The low address bits pick the slice, and the returned value is zero-extended.

When a read misses both buffers, the block discards both and fetches the line on demand. It stalls the requester until the flash has taken its programmed wait states. The first hit in a buffer starts a fetch of the following line into the other buffer. Straight-line code therefore finds its next line already loaded, even when its reads are spread out in time.

The flash is smaller than the region it is mapped into. Address bits above the flash size are ignored, so both the line tags and the next-line step wrap around the flash.

Top module: `flash_prefetch`

## Requirements
- R1: A read that misses both buffers, with no fetch of its line under way, keeps `cpu_ready` low for `cfg_ws`+2 cycles, counting the cycle it first appears. In the next cycle, `cpu_ready` is high with the correct data.
- R2: A read whose line is held in a buffer gets `cpu_ready` high in the cycle it is presented, which means zero added wait. `cpu_ready` is never high without `cpu_req`.
- R3: `cpu_size` selects the read width: 0 is a byte, 1 a halfword, 2 a word. Bytes are little-endian from the addressed byte, and unused upper bits read as zero.
- R4: The first hit in a buffer holding line n starts a fetch of line n+1 into the other buffer. Once that fetch is done, a read of line n+1 hits with zero wait.
- R5: A read of the line that is currently being prefetched waits only for the rest of that fetch and does not restart it. Presented in the cycle right after the triggering hit, it sees `cfg_ws`+1 cycles with `cpu_ready` low.
- R6: With `cfg_narrow`=0 a line is 16 bytes, selected by address bits [9:4]. With `cfg_narrow`=1 a line is 8 bytes, selected by address bits [9:3], and only the low 64 bits of the flash data are kept.
- R7: Address bits at or above bit 10 (the flash size) are ignored. An aliased address returns the same data, and it hits the buffer that holds the aliased line.
- R8: A change of `cfg_ws` or `cfg_narrow` invalidates both buffers and aborts any fetch. In the cycle of the change, no aligned read completes. The next read then misses and takes the new latency.
- R9: A halfword read at an odd address, a word read not on a 4-byte boundary, or a size code of 3 gives `cpu_err`=1 and `cpu_ready`=1 in the same cycle, with `cpu_rdata`=0. The buffers are left unchanged.
- R10: While reset is active and just after it, `cpu_ready`, `cpu_err` and `fl_rd` are low.
- R11: The line after the last line of the flash is line 0, so a prefetch from the top line wraps around to address 0.
- R12: A miss while a prefetch of a different line is under way abandons that prefetch and starts a demand fetch, with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ws | input | WS_W | Flash wait states per access |
| cfg_narrow | input | 1 | 1 selects the 64-bit line width |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_ready | output | 1 | Read completes this cycle |
| cpu_err | output | 1 | Unaligned or illegal-size read |
| cpu_rdata | output | 32 | Zero-extended read data |
| fl_rd | output | 1 | Flash access in progress |
| fl_line | output | FLASH_AW-3 | Flash address of the line in 8-byte units |
| fl_data | input | 128 | Flash read data, sampled in the last access cycle |

## Verification
The hardest case to reach is a request that lands while a prefetch is half done. The bench has to tell whether that prefetch is joined (same line) or abandoned (different line), and neither choice is visible in the data. The stimulus reaches it with back-to-back tasks. The first read's ready cycle is the hit that launches the prefetch, and the next request appears on the very next cycle. The bench counts stalled cycles to separate the `cfg_ws`+1 case from the `cfg_ws`+2 case. A nonzero wait-state setting keeps the two counts apart.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } fpa_size_e;

  localparam int LINE_W = 128;
endpackage

// File: rtl/fpa_line_buf.sv
module fpa_line_buf #(
  parameter int TAG_W  = 7,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [LINE_W-1:0] load_data,
  output logic              vld,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] data
);
  logic             vld_d;
  logic [TAG_W-1:0] tag_d;

  always_comb begin
    vld_d = vld;
    tag_d = tag;
    if (load) begin
      vld_d = 1'b1;
      tag_d = load_tag;
    end else if (clr) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      tag <= '0;
    end else begin
      vld <= vld_d;
      tag <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end
endmodule

// File: rtl/fpa_fetch_eng.sv
module fpa_fetch_eng #(
  parameter int WS_W  = 4,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [TAG_W-1:0] start_line,
  input  logic [WS_W-1:0]  ws,
  output logic             busy,
  output logic [TAG_W-1:0] line,
  output logic             done
);
  logic             busy_d;
  logic [WS_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0] line_d;

  assign done = busy && (cnt_q == '0);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    line_d = line;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = ws;
      line_d = start_line;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      line  <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
      line  <= line_d;
    end
  end
endmodule

// File: rtl/fpa_slice.sv
module fpa_slice
  import fpa_pkg::*;
(
  input  logic [LINE_W-1:0] line_data,
  input  logic [3:0]        off,
  input  fpa_size_e         size,
  output logic [31:0]       rdata
);
  logic [LINE_W-1:0] shifted;

  always_comb begin
    shifted = line_data >> {off, 3'b000};
    unique case (size)
      SZ_BYTE: rdata = {24'b0, shifted[7:0]};
      SZ_HALF: rdata = {16'b0, shifted[15:0]};
      SZ_WORD: rdata = shifted[31:0];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_prefetch.sv
module flash_prefetch
  import fpa_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int FLASH_AW = 10,
  parameter int WS_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WS_W-1:0]       cfg_ws,
  input  logic                  cfg_narrow,
  input  logic                  cpu_req,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [1:0]            cpu_size,
  output logic                  cpu_ready,
  output logic                  cpu_err,
  output logic [31:0]           cpu_rdata,
  output logic                  fl_rd,
  output logic [FLASH_AW-4:0]   fl_line,
  input  logic [LINE_W-1:0]     fl_data
);
  localparam int TAG_W = FLASH_AW - 3;
  localparam int NBUF  = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // registered configuration, used to detect a change
  logic [WS_W-1:0] ws_q;
  logic            nar_q;
  logic            cfg_chg;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ws_q  <= '0;
      nar_q <= 1'b0;
    end else begin
      ws_q  <= cfg_ws;
      nar_q <= cfg_narrow;
    end
  end
  assign cfg_chg = (cfg_ws != ws_q) || (cfg_narrow != nar_q);

  fpa_size_e        size;
  logic [TAG_W-1:0] req_tag, step, next_tag;
  logic [3:0]       off;
  logic             unal, go, hit, hit_idx, other, have_next;
  logic             demand, pf, start, tgt_d, tgt_q;
  logic [TAG_W-1:0] start_line;
  logic             eng_busy, eng_done;
  logic [TAG_W-1:0] eng_line;
  logic [LINE_W-1:0] load_data;

  logic [NBUF-1:0]   buf_vld, hit_v, buf_clr, buf_load;
  logic [TAG_W-1:0]  buf_tag  [NBUF];
  logic [LINE_W-1:0] buf_data [NBUF];

  assign size    = fpa_size_e'(cpu_size);
  assign req_tag = cfg_narrow ? cpu_addr[FLASH_AW-1:3] : {cpu_addr[FLASH_AW-1:4], 1'b0};
  assign off     = cfg_narrow ? {1'b0, cpu_addr[2:0]} : cpu_addr[3:0];
  assign step    = cfg_narrow ? TAG_W'(1) : TAG_W'(2);
  assign unal    = (size == SZ_HALF && cpu_addr[0]) ||
                   (size == SZ_WORD && cpu_addr[1:0] != 2'b00) ||
                   (size == SZ_BAD);

  genvar gi;
  generate
    for (gi = 0; gi < NBUF; gi++) begin : g_buf
      assign hit_v[gi]    = buf_vld[gi] && (buf_tag[gi] == req_tag) && !cfg_chg;
      assign buf_clr[gi]  = cfg_chg || demand || (pf && (other == gi[0]));
      assign buf_load[gi] = eng_done && (tgt_q == gi[0]) && !cfg_chg && !demand;
      fpa_line_buf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) buf_i (
        .clk       (clk),
        .rst_n     (srst_n),
        .clr       (buf_clr[gi]),
        .load      (buf_load[gi]),
        .load_tag  (eng_line),
        .load_data (load_data),
        .vld       (buf_vld[gi]),
        .tag       (buf_tag[gi]),
        .data      (buf_data[gi])
      );
    end
  endgenerate

  assign hit       = |hit_v;
  assign hit_idx   = hit_v[1];
  assign other     = ~hit_idx;
  assign next_tag  = buf_tag[hit_idx] + step;
  assign have_next = buf_vld[other] && (buf_tag[other] == next_tag);

  always_comb begin
    go         = cpu_req && !unal && !cfg_chg;
    demand     = go && !hit && !(eng_busy && eng_line == req_tag);
    pf         = go && hit && !eng_busy && !have_next;
    start      = demand || pf;
    start_line = demand ? req_tag : next_tag;
    tgt_d      = demand ? 1'b0 : other;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    tgt_q <= 1'b0;
    else if (start) tgt_q <= tgt_d;
  end

  fpa_fetch_eng #(.WS_W(WS_W), .TAG_W(TAG_W)) eng_i (
    .clk        (clk),
    .rst_n      (srst_n),
    .start      (start),
    .abort      (cfg_chg),
    .start_line (start_line),
    .ws         (cfg_ws),
    .busy       (eng_busy),
    .line       (eng_line),
    .done       (eng_done)
  );

  assign load_data = cfg_narrow ? {{(LINE_W/2){1'b0}}, fl_data[LINE_W/2-1:0]} : fl_data;

  logic [31:0] slice;
  fpa_slice slice_i (
    .line_data (buf_data[hit_idx]),
    .off       (off),
    .size      (size),
    .rdata     (slice)
  );

  assign cpu_ready = cpu_req && (unal || hit);
  assign cpu_err   = cpu_req && unal;
  assign cpu_rdata = (cpu_req && !unal && hit) ? slice : 32'b0;
  assign fl_rd     = eng_busy;
  assign fl_line   = eng_line;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int ADDR_W = 32,
  parameter int WS_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WS_W-1:0]   cfg_ws,
  input logic              cfg_narrow,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        cpu_size,
  input logic              cpu_ready,
  input logic              cpu_err,
  input logic [31:0]       cpu_rdata
);
  logic [1:0] arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              arm_q <= 2'd0;
    else if (arm_q != 2'd3)  arm_q <= arm_q + 2'd1;
  end

  // R2
  a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R9
  a_r9_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_req);

  // R9
  a_r9_unaligned_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_size == 2'd2 && cpu_addr[1:0] != 2'b00)
      |-> (cpu_err && cpu_ready && cpu_rdata == 32'b0));

  // R3
  a_r3_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_err && cpu_size == 2'd0) |-> (cpu_rdata[31:8] == 24'b0));

  // R8
  a_r8_cfg_change_stalls: assert property (@(posedge clk) disable iff (!rst_n || arm_q != 2'd3)
    (cpu_req && !cpu_err &&
     (cfg_ws != $past(cfg_ws) || cfg_narrow != $past(cfg_narrow))) |-> !cpu_ready);
endmodule

bind flash_prefetch fpa_checker #(.ADDR_W(ADDR_W), .WS_W(WS_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_ws     (cfg_ws),
  .cfg_narrow (cfg_narrow),
  .cpu_req    (cpu_req),
  .cpu_addr   (cpu_addr),
  .cpu_size   (cpu_size),
  .cpu_ready  (cpu_ready),
  .cpu_err    (cpu_err),
  .cpu_rdata  (cpu_rdata)
);

// File: tb/flash_prefetch_tb_top.sv
module flash_prefetch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cfg_ws = '0;
  logic         cfg_narrow = 1'b0;
  logic         cpu_req = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [1:0]   cpu_size = '0;
  logic         cpu_ready, cpu_err, fl_rd;
  logic [31:0]  cpu_rdata;
  logic [6:0]   fl_line;
  logic [127:0] fl_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ws(cfg_ws), .cfg_narrow(cfg_narrow),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .fl_rd(fl_rd), .fl_line(fl_line), .fl_data(fl_data)
  );

  function automatic logic [7:0] fbyte(input int a);
    return 8'(((a & 1023) * 13) + 5);
  endfunction

  always_comb begin
    for (int k = 0; k < 16; k++) fl_data[8*k +: 8] = fbyte(int'({fl_line, 3'b000}) + k);
  end

  function automatic logic [31:0] expv(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] e = '0;
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) e[8*k +: 8] = fbyte(int'(a[9:0]) + k);
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one read: back to back with the previous one; checks wait count and data
  task automatic rd(input string req, input logic [31:0] a, input logic [1:0] sz,
                    input int exp_wait, input bit exp_err = 1'b0);
    int w = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_size = sz;
    #4;
    while (!cpu_ready && w < 64) begin
      w++;
      @(negedge clk);
      #4;
    end
    chk({req, " wait"}, 32'(w), 32'(exp_wait));
    chk({req, " err"}, 32'(cpu_err), 32'(exp_err));
    chk({req, " data"}, cpu_rdata, exp_err ? 32'b0 : expv(a, sz));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [3:0] ws, input logic nar);
    @(negedge clk);
    cpu_req = 1'b0; cfg_ws = ws; cfg_narrow = nar;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    #3;
    chk("R10 ready in reset", 32'(cpu_ready), 0);
    chk("R10 err in reset", 32'(cpu_err), 0);
    chk("R10 fl_rd in reset", 32'(fl_rd), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 fl_rd after reset", 32'(fl_rd), 0);
    chk("R10 ready after reset", 32'(cpu_ready), 0);
  endtask

  task automatic t_miss_hit_prefetch;
    set_cfg(4'd2, 1'b0);
    rd("R1 miss ws2", 32'h000, 2'd2, 4);
    rd("R2 hit word", 32'h004, 2'd2, 0);
    rd("R3 byte", 32'h005, 2'd0, 0);
    rd("R3 half", 32'h006, 2'd1, 0);
    idle(10);
    rd("R4 prefetched line", 32'h010, 2'd2, 0);
    rd("R5 join prefetch", 32'h020, 2'd2, 3);
    rd("R12 abandon prefetch", 32'h200, 2'd2, 4);
    rd("R7 alias 0x600", 32'h600, 2'd0, 0);
    rd("R7 alias high", 32'hFFFF_0208, 2'd2, 0);
    rd("R9 odd half", 32'h201, 2'd1, 0, 1'b1);
    rd("R9 misaligned word", 32'h202, 2'd2, 0, 1'b1);
    rd("R9 size code 3", 32'h204, 2'd3, 0, 1'b1);
    rd("R9 buffers kept", 32'h204, 2'd2, 0);
    idle(2);
  endtask

  task automatic t_cfg_wrap;
    set_cfg(4'd1, 1'b0);
    rd("R8 ws change miss", 32'h208, 2'd2, 3);
    rd("R1 last line miss", 32'h3F0, 2'd2, 0 + 3);
    idle(10);
    rd("R11 wrap to zero", 32'h000, 2'd2, 0);
    set_cfg(4'd0, 1'b0);
    rd("R1 miss ws0", 32'h100, 2'd2, 2);
    idle(2);
  endtask

  task automatic t_narrow;
    set_cfg(4'd1, 1'b1);
    rd("R8 width change miss", 32'h000, 2'd2, 3);
    idle(10);
    rd("R6 narrow next line", 32'h008, 2'd2, 0);
    rd("R6 narrow same line", 32'h00C, 2'd2, 0);
    rd("R6 narrow 8-byte boundary", 32'h018, 2'd2, 3);
    idle(2);
  endtask

  initial begin
    t_reset();
    t_miss_hit_prefetch();
    t_cfg_wrap();
    t_narrow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule